// File: doc/BRIEF.md
# Loadable Counter with Decade Mode

A synchronous up-counter whose register can be preset from a parallel data input, advanced by one under a count enable, or held. A carry output goes high in the cycle where the next count wraps the stage. That lets several stages be chained into a wider counter: feed the carry of one stage into the count enable of the next.

A mode input makes the stage count in decimal, 0 through 9. The wrap from 9 does not use a separate clear path. It goes through the same parallel-load path that the external preset uses, with zero as the load value. When external load and the internal decade wrap fall in the same cycle, the external load wins.

Top module: `loadable_counter`

## Requirements
- R1: Driving rst_ni low clears value_o to 0000 at once, without waiting for a clock edge. While rst_ni is low, value_o stays at 0000 whatever load_i and count_i are.
- R2: With load_i=1 on a rising edge, value_o takes data_i. This holds for both values of count_i and in both modes.
- R3: With load_i=0 and count_i=1, value_o advances by one on the edge. In decade mode this applies only while value_o is not 9.
- R4: With load_i=0 and count_i=0, value_o keeps its value across the edge.
- R5: In binary mode (decade_i=0), counting from 1111 gives 0000.
- R6: In binary mode, carry_o is 1 in a cycle exactly when value_o=1111, count_i=1 and load_i=0. It is combinational from those inputs in the same cycle.
- R7: In decade mode (decade_i=1), when value_o=9 (1001) with count_i=1 and load_i=0, the next edge gives 0000, and carry_o is 1 during that cycle. In binary mode, 9 counts on to 10.
- R8: In decade mode, a loaded value above 9 counts up in binary until it wraps from 1111 to 0000. carry_o stays 0 for those values, including 1111.
- R9: In decade mode, with value_o=9, load_i=1 and count_i=1, the counter loads data_i instead of wrapping to 0000, and carry_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Parallel preset request |
| count_i | input | 1 | Count enable |
| data_i | input | 4 | Preset value |
| decade_i | input | 1 | 1 = count 0..9, 0 = binary |
| value_o | output | 4 | Counter value |
| carry_o | output | 1 | Wrap indication for cascading |

## Verification
A wrong next-state term shows up on value_o one edge after the stimulus that exercises it. Examples are a missing toggle enable or a wrong decade wrap value. A decade compare that decodes the wrong state has two symptoms at once. carry_o pulses in the same cycle at the wrong value, and the next edge loads zero from the wrong value. A priority error between load and the internal wrap shows as the wrong value_o one edge after a cycle with both requests. The directed scenarios set the counter right below each wrap point in each mode, so each fault appears within two or three cycles.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cnt_toggle_chain.sv
module cnt_toggle_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] value_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] toggle_o
);
  // Parallel gating: each bit sees one wide AND of all lower bits.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (b == 0) begin : g_lsb
      assign toggle_o[b] = en_i;
    end else begin : g_upper
      assign toggle_o[b] = en_i & (&value_i[b-1:0]);
    end
  end
endmodule

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int DECADE_LAST = 9
) (
  input  logic [WIDTH-1:0] value_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             load_i,
  input  logic             count_i,
  input  logic             decade_i,
  output cnt_op_e          op_o,
  output logic [WIDTH-1:0] load_val_o,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] LastDec = WIDTH'(DECADE_LAST);
  localparam logic [WIDTH-1:0] AllOnes = '1;

  logic at_dec_last;
  logic at_bin_last;
  logic wrap_dec;

  assign at_dec_last = (value_i == LastDec);
  assign at_bin_last = (value_i == AllOnes);
  assign wrap_dec    = decade_i & at_dec_last & count_i & ~load_i;

  always_comb begin
    op_o       = OP_HOLD;
    load_val_o = data_i;
    if (load_i) begin
      op_o = OP_LOAD;
    end else if (wrap_dec) begin
      // decade wrap reuses the load path with a zero value
      op_o       = OP_LOAD;
      load_val_o = '0;
    end else if (count_i) begin
      op_o = OP_INC;
    end
  end

  assign carry_o = count_i & ~load_i & (decade_i ? at_dec_last : at_bin_last);
endmodule

// File: rtl/loadable_counter.sv
module loadable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int DECADE_LAST = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             count_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             decade_i,
  output logic [WIDTH-1:0] value_o,
  output logic             carry_o
);
  cnt_op_e          op;
  logic [WIDTH-1:0] load_val;
  logic [WIDTH-1:0] toggle;
  logic [WIDTH-1:0] value_q;
  logic [WIDTH-1:0] value_d;

  cnt_ctrl #(.WIDTH(WIDTH), .DECADE_LAST(DECADE_LAST)) u_ctrl (
    .value_i   (value_q),
    .data_i    (data_i),
    .load_i    (load_i),
    .count_i   (count_i),
    .decade_i  (decade_i),
    .op_o      (op),
    .load_val_o(load_val),
    .carry_o   (carry_o)
  );

  cnt_toggle_chain #(.WIDTH(WIDTH)) u_chain (
    .value_i (value_q),
    .en_i    (op == OP_INC),
    .toggle_o(toggle)
  );

  always_comb begin
    unique case (op)
      OP_LOAD: value_d = load_val;
      OP_INC:  value_d = value_q ^ toggle;
      default: value_d = value_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) value_q <= '0;
    else         value_q <= value_d;
  end

  assign value_o = value_q;
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
  parameter int WIDTH       = 4,
  parameter int DECADE_LAST = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             count_i,
  input logic [WIDTH-1:0] data_i,
  input logic             decade_i,
  input logic [WIDTH-1:0] value_o,
  input logic             carry_o
);
  localparam logic [WIDTH-1:0] LastDec = WIDTH'(DECADE_LAST);

  // R1
  rst_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> value_o == '0);

  // R2
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> value_o == $past(data_i));

  // R3
  bin_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && count_i && !decade_i) |=> value_o == WIDTH'($past(value_o) + 1'b1));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !count_i) |=> $stable(value_o));

  // R6
  carry_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (count_i && !load_i));

  // R7
  dec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decade_i && !load_i && count_i && value_o == LastDec) |=> value_o == '0);
endmodule

bind loadable_counter cnt_checker #(.WIDTH(WIDTH), .DECADE_LAST(DECADE_LAST)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .count_i (count_i),
  .data_i  (data_i),
  .decade_i(decade_i),
  .value_o (value_o),
  .carry_o (carry_o)
);

// File: tb/tb_loadable_counter.sv
module tb_loadable_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic       count_i = 1'b0;
  logic [3:0] data_i = 4'd0;
  logic       decade_i = 1'b0;
  logic [3:0] value_o;
  logic       carry_o;

  int n_checks = 0;
  int n_fail = 0;

  loadable_counter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .count_i(count_i),
    .data_i(data_i), .decade_i(decade_i), .value_o(value_o), .carry_o(carry_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic l, input logic c, input logic [3:0] d, input logic m);
    @(negedge clk_i);
    load_i = l; count_i = c; data_i = d; decade_i = m;
    #1;
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic test_reset();
    chk("R1 reset value", value_o, 4'd0);
    apply(1'b1, 1'b1, 4'd7, 1'b0);
    tick();
    chk("R1 load ignored in reset", value_o, 4'd0);
    apply(1'b0, 1'b0, 4'd0, 1'b0);
    rst_ni = 1'b1;
  endtask

  task automatic test_load();
    apply(1'b1, 1'b1, 4'd10, 1'b0);
    tick();
    chk("R2 load with count", value_o, 4'd10);
    apply(1'b1, 1'b0, 4'd5, 1'b0);
    tick();
    chk("R2 load without count", value_o, 4'd5);
  endtask

  task automatic test_hold();
    apply(1'b0, 1'b0, 4'd3, 1'b0);
    tick();
    chk("R4 hold", value_o, 4'd5);
    tick();
    chk("R4 hold again", value_o, 4'd5);
  endtask

  task automatic test_count();
    apply(1'b1, 1'b0, 4'd0, 1'b0);
    tick();
    for (int i = 1; i <= 3; i++) begin
      apply(1'b0, 1'b1, 4'd0, 1'b0);
      chk("R6 no carry mid count", {3'b0, carry_o}, 4'd0);
      tick();
      chk("R3 increment", value_o, 4'(i));
    end
  endtask

  task automatic test_bin_wrap();
    apply(1'b1, 1'b1, 4'd15, 1'b0);
    chk("R6 no carry under load", {3'b0, carry_o}, 4'd0);
    tick();
    apply(1'b0, 1'b0, 4'd0, 1'b0);
    chk("R6 no carry without count", {3'b0, carry_o}, 4'd0);
    apply(1'b0, 1'b1, 4'd0, 1'b0);
    chk("R6 carry at 1111", {3'b0, carry_o}, 4'd1);
    tick();
    chk("R5 binary wrap", value_o, 4'd0);
  endtask

  task automatic test_decade();
    apply(1'b1, 1'b0, 4'd8, 1'b1);
    tick();
    apply(1'b0, 1'b1, 4'd0, 1'b1);
    chk("R7 no carry at 8", {3'b0, carry_o}, 4'd0);
    tick();
    chk("R3 decade 8 to 9", value_o, 4'd9);
    chk("R7 carry at 9", {3'b0, carry_o}, 4'd1);
    tick();
    chk("R7 decade wrap", value_o, 4'd0);
    apply(1'b1, 1'b0, 4'd9, 1'b0);
    tick();
    apply(1'b0, 1'b1, 4'd0, 1'b0);
    chk("R7 binary no carry at 9", {3'b0, carry_o}, 4'd0);
    tick();
    chk("R7 binary 9 to 10", value_o, 4'd10);
  endtask

  task automatic test_decade_high();
    apply(1'b1, 1'b0, 4'd12, 1'b1);
    tick();
    for (int v = 13; v <= 15; v++) begin
      apply(1'b0, 1'b1, 4'd0, 1'b1);
      chk("R8 no carry above 9", {3'b0, carry_o}, 4'd0);
      tick();
      chk("R8 binary steps above 9", value_o, 4'(v));
    end
    apply(1'b0, 1'b1, 4'd0, 1'b1);
    chk("R8 no carry at 1111", {3'b0, carry_o}, 4'd0);
    tick();
    chk("R8 wrap from 1111", value_o, 4'd0);
  endtask

  task automatic test_load_prio();
    apply(1'b1, 1'b0, 4'd9, 1'b1);
    tick();
    apply(1'b1, 1'b1, 4'd4, 1'b1);
    chk("R9 no carry when loading", {3'b0, carry_o}, 4'd0);
    tick();
    chk("R9 load beats wrap", value_o, 4'd4);
  endtask

  task automatic test_async_reset();
    apply(1'b0, 1'b0, 4'd0, 1'b0);
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear", value_o, 4'd0);
    apply(1'b0, 1'b0, 4'd0, 1'b0);
    rst_ni = 1'b1;
  endtask

  initial begin
    test_reset();
    test_load();
    test_hold();
    test_count();
    test_bin_wrap();
    test_decade();
    test_decade_high();
    test_load_prio();
    test_async_reset();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule